// File: doc/BRIEF.md
# Circular-Buffer DMA Channel with Modulo Source Addressing

This block is one memory-to-peripheral DMA channel. It streams a circular buffer in memory into one peripheral data register, usually a transmit FIFO. Each pulse on the request input starts a minor loop. A minor loop is a burst of `cfg_nbytes` bytes, moved as 32-bit beats. Each beat is one memory read followed by one peripheral write. A major loop counter counts finished minor loops. When it reaches zero it sets a sticky interrupt flag and reloads itself.

The source address moves by a signed offset on every beat. Only its low `cfg_src_mod` bits change, so the address wraps inside an aligned window of 2^`cfg_src_mod` bytes. The upper bits stay frozen, and no comparator is needed. A value of 0 turns the window off. The destination address moves by its own signed offset and has no window. An offset of 0 makes every write hit the same register.

After the last beat of a loop, both addresses carry on from where they stopped. No adjustment is applied at the end of a major loop. Software programs the configuration while `cfg_en` is low. The channel reloads its address pointers and the major counter from that configuration every idle cycle while disabled.

The controlling state machine has four states:
- IDLE waits. It goes to READ (transition *start*) when the channel is enabled and a request is present or pending.
- READ issues the memory read and always goes to WRITE (*fetch*).
- WRITE issues the peripheral write. It goes back to READ (*next beat*) while beats remain, or to FINISH (*last beat*).
- FINISH steps the major counter and returns to IDLE (*retire*).

`cfg_nbytes` is expected to be a nonzero multiple of 4. A value below 4 moves one beat. `cfg_major` of 0 behaves as 1.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset, `mem_rd_en`, `per_wr_en` and `irq` are 0.
- R2: Each served request produces exactly `cfg_nbytes/4` peripheral writes. The data of each write equals the memory word returned for that beat's source address. The word arrives on `mem_rd_data` in the cycle after `mem_rd_en`.
- R3: Between beats, the source address becomes (A & K) | ((A + soff) & ~K), where K has ones in bit positions `cfg_src_mod` and above. The bits at and above `cfg_src_mod` never change. When `cfg_src_mod` is 0, the full address is incremented.
- R4: The destination address moves by the sign-extended `cfg_dst_off` after each write, across the full width. With an offset of 0, every write uses `cfg_dst_addr`.
- R5: Source and destination addresses continue without any adjustment from one minor loop to the next and across major loop completion.
- R6: At the completion of every `cfg_major`-th minor loop, the major counter reloads and `irq` becomes 1, two cycles after the last write of that loop.
- R7: `irq` stays 1 until `irq_clr` is sampled high. If a completion and `irq_clr` coincide, `irq` is 1.
- R8: A request that arrives while a minor loop is in progress is held and served after that loop. Several such requests during one loop merge into a single further loop.
- R9: While `cfg_en` is low, requests are dropped. In idle, the pointers and the major counter reload from configuration. Lowering `cfg_en` during a loop lets that loop finish.
- R10: A peripheral write occurs only in the cycle right after a memory read, and never in the same cycle as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable; configuration is reloaded while low and idle |
| cfg_src_base | input | ADDR_W | Start address of the source buffer |
| cfg_dst_addr | input | ADDR_W | Peripheral register address |
| cfg_src_off | input | OFF_W | Signed source step per beat, in bytes |
| cfg_dst_off | input | OFF_W | Signed destination step per beat, in bytes |
| cfg_src_mod | input | SMOD_W | Number of low source bits that advance; 0 disables the window |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_major | input | MAJ_W | Minor loops per completion interrupt |
| req | input | 1 | Peripheral service request |
| irq_clr | input | 1 | Clears the completion flag |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after the strobe |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_wr_addr | output | ADDR_W | Peripheral write address |
| per_wr_data | output | DATA_W | Peripheral write data |
| irq | output | 1 | Sticky major-loop completion flag |

## Verification
The assertions check several rules on every cycle:
- Reads and writes alternate strictly.
- Successive read addresses keep the bits above the modulo window frozen.
- A zero destination offset holds the write address fixed.
- The completion flag only rises two cycles after a write, and stays high until cleared.

Other behaviours depend on counting across many cycles or on the exact order of stimuli, so only the bench scenarios show them:
- the exact address sequence through a wrap, including downward wraps with a negative offset and carries when the window is off;
- the beat count per loop;
- the interrupt arriving on exactly the right minor loop;
- merging of requests that arrive during a loop;
- a completion winning over a simultaneous clear;
- requests dropped while disabled, and the reload on re-enable.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } chan_state_e;

    // Strobes from the sequencer to the datapath
    typedef struct packed {
        logic start;       // minor loop accepted
        logic reload;      // idle and disabled: take configuration
        logic rd;          // memory read this cycle
        logic src_step;    // advance source pointer
        logic wr;          // peripheral write this cycle
        logic dst_step;    // advance destination pointer
        logic beat_step;   // one beat retired
        logic major_step;  // one minor loop retired
    } fsm_ctl_t;

endpackage

// File: rtl/ring_dma_addr_step.sv
module ring_dma_addr_step #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int SMOD_W = 5,
    parameter bit MODULO = 1'b1
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [OFF_W-1:0]  off,
    input  logic [SMOD_W-1:0] smod,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] sum;

    assign off_ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    assign sum     = cur + off_ext;

    generate
        if (MODULO) begin : g_modulo
            // Bits at and above smod are frozen; smod == 0 freezes nothing
            logic [ADDR_W-1:0] keep_mask;
            assign keep_mask = (smod == '0) ? '0 : ({ADDR_W{1'b1}} << smod);
            assign nxt = (cur & keep_mask) | (sum & ~keep_mask);
        end else begin : g_linear
            logic unused_smod;
            assign unused_smod = ^smod;
            assign nxt = sum;
        end
    endgenerate

endmodule

// File: rtl/ring_dma_loop_ctr.sv
module ring_dma_loop_ctr #(
    parameter int NB_W    = 12,
    parameter int MAJ_W   = 16,
    parameter int BEAT_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB_W-1:0]  cfg_nbytes,
    input  logic [MAJ_W-1:0] cfg_major,
    input  logic             load_minor,
    input  logic             beat_step,
    input  logic             reload_major,
    input  logic             major_step,
    input  logic             irq_clr,
    output logic             last_beat,
    output logic             irq
);

    logic [NB_W-1:0]  beats_cfg;
    logic [NB_W-1:0]  beat_left_q;
    logic [MAJ_W-1:0] major_left_q;
    logic             expire;

    assign beats_cfg = NB_W'(cfg_nbytes >> BEAT_SH);
    assign last_beat = (beat_left_q <= NB_W'(1));
    assign expire    = major_step && (major_left_q <= MAJ_W'(1));

    // Beats remaining in the current minor loop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_left_q <= '0;
        end else if (load_minor) begin
            beat_left_q <= beats_cfg;
        end else if (beat_step && !last_beat) begin
            beat_left_q <= beat_left_q - NB_W'(1);
        end
    end

    // Minor loops remaining before completion; reloads on expiry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            major_left_q <= '0;
        end else if (reload_major || expire) begin
            major_left_q <= cfg_major;
        end else if (major_step) begin
            major_left_q <= major_left_q - MAJ_W'(1);
        end
    end

    // Sticky completion flag; a completion wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (expire) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/ring_dma_fsm.sv
module ring_dma_fsm
    import ring_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     req,
    input  logic     last_beat,
    output fsm_ctl_t ctl
);

    chan_state_e state_q;
    chan_state_e state_d;
    logic        pend_q;
    logic        go;

    assign go = en && (req || pend_q);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = last_beat ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and held request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!en) begin
                pend_q <= 1'b0;
            end else if (state_q == ST_IDLE && go) begin
                pend_q <= 1'b0;
            end else if (req) begin
                pend_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctl.start  = go;
                ctl.reload = !en;
            end
            ST_READ: begin
                ctl.rd       = 1'b1;
                ctl.src_step = 1'b1;
            end
            ST_WRITE: begin
                ctl.wr        = 1'b1;
                ctl.dst_step  = 1'b1;
                ctl.beat_step = 1'b1;
            end
            ST_FINISH: begin
                ctl.major_step = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
    import ring_dma_pkg::*;
#(
    parameter int  ADDR_W  = 32,
    parameter int  DATA_W  = 32,
    parameter int  OFF_W   = 16,
    parameter int  NB_W    = 12,
    parameter int  MAJ_W   = 16,
    localparam int SMOD_W  = $clog2(ADDR_W),
    localparam int BEAT_SH = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_src_base,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [OFF_W-1:0]  cfg_src_off,
    input  logic [OFF_W-1:0]  cfg_dst_off,
    input  logic [SMOD_W-1:0] cfg_src_mod,
    input  logic [NB_W-1:0]   cfg_nbytes,
    input  logic [MAJ_W-1:0]  cfg_major,
    input  logic              req,
    input  logic              irq_clr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              per_wr_en,
    output logic [ADDR_W-1:0] per_wr_addr,
    output logic [DATA_W-1:0] per_wr_data,
    output logic              irq
);

    fsm_ctl_t          ctl;
    logic              last_beat;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ADDR_W-1:0] src_nxt;
    logic [ADDR_W-1:0] dst_nxt;

    ring_dma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .req       (req),
        .last_beat (last_beat),
        .ctl       (ctl)
    );

    ring_dma_loop_ctr #(
        .NB_W    (NB_W),
        .MAJ_W   (MAJ_W),
        .BEAT_SH (BEAT_SH)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_nbytes   (cfg_nbytes),
        .cfg_major    (cfg_major),
        .load_minor   (ctl.start),
        .beat_step    (ctl.beat_step),
        .reload_major (ctl.reload),
        .major_step   (ctl.major_step),
        .irq_clr      (irq_clr),
        .last_beat    (last_beat),
        .irq          (irq)
    );

    ring_dma_addr_step #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .SMOD_W (SMOD_W),
        .MODULO (1'b1)
    ) u_src_step (
        .cur  (src_q),
        .off  (cfg_src_off),
        .smod (cfg_src_mod),
        .nxt  (src_nxt)
    );

    ring_dma_addr_step #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .SMOD_W (SMOD_W),
        .MODULO (1'b0)
    ) u_dst_step (
        .cur  (dst_q),
        .off  (cfg_dst_off),
        .smod ('0),
        .nxt  (dst_nxt)
    );

    // Address pointers: loaded while disabled, stepped per beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (ctl.reload) begin
                src_q <= cfg_src_base;
                dst_q <= cfg_dst_addr;
            end else begin
                if (ctl.src_step) src_q <= src_nxt;
                if (ctl.dst_step) dst_q <= dst_nxt;
            end
        end
    end

    assign mem_rd_en   = ctl.rd;
    assign mem_rd_addr = src_q;
    assign per_wr_en   = ctl.wr;
    assign per_wr_addr = dst_q;
    assign per_wr_data = mem_rd_data;

endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int SMOD_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [SMOD_W-1:0] cfg_src_mod,
    input logic [OFF_W-1:0]  cfg_dst_off,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              per_wr_en,
    input logic [ADDR_W-1:0] per_wr_addr,
    input logic              irq,
    input logic              irq_clr
);

    logic [ADDR_W-1:0] prev_rd_q;
    logic              prev_rd_ok_q;
    logic [ADDR_W-1:0] prev_wr_q;
    logic              prev_wr_ok_q;
    logic [ADDR_W-1:0] frozen_mask;

    assign frozen_mask = {ADDR_W{1'b1}} << cfg_src_mod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rd_q    <= '0;
            prev_rd_ok_q <= 1'b0;
            prev_wr_q    <= '0;
            prev_wr_ok_q <= 1'b0;
        end else begin
            if (!cfg_en) begin
                prev_rd_ok_q <= 1'b0;
                prev_wr_ok_q <= 1'b0;
            end else begin
                if (mem_rd_en) begin
                    prev_rd_q    <= mem_rd_addr;
                    prev_rd_ok_q <= 1'b1;
                end
                if (per_wr_en) begin
                    prev_wr_q    <= per_wr_addr;
                    prev_wr_ok_q <= 1'b1;
                end
            end
        end
    end

    a_r10_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr_en |-> $past(mem_rd_en));

    a_r10_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && per_wr_en));

    a_r3_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && prev_rd_ok_q && cfg_src_mod != '0)
        |-> ((mem_rd_addr & frozen_mask) == (prev_rd_q & frozen_mask)));

    a_r4_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr_en && prev_wr_ok_q && cfg_dst_off == '0)
        |-> (per_wr_addr == prev_wr_q));

    a_r6_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(per_wr_en, 2));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

endmodule

bind ring_dma_chan ring_dma_chan_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SMOD_W (SMOD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_src_mod (cfg_src_mod),
    .cfg_dst_off (cfg_dst_off),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .per_wr_en   (per_wr_en),
    .per_wr_addr (per_wr_addr),
    .irq         (irq),
    .irq_clr     (irq_clr)
);

// File: tb/ring_dma_chan_tb.sv
module ring_dma_chan_tb;

    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [AW-1:0] cfg_src_base = '0;
    logic [AW-1:0] cfg_dst_addr = '0;
    logic [15:0]   cfg_src_off = '0;
    logic [15:0]   cfg_dst_off = '0;
    logic [4:0]    cfg_src_mod = '0;
    logic [11:0]   cfg_nbytes = '0;
    logic [15:0]   cfg_major = '0;
    logic          req = 1'b0;
    logic          irq_clr = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic          per_wr_en;
    logic [AW-1:0] per_wr_addr;
    logic [DW-1:0] per_wr_data;
    logic          irq;

    int   n_chk = 0;
    int   n_bad = 0;
    int   writes = 0;
    int   exp_writes = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    logic [AW-1:0] m_src;
    logic [AW-1:0] m_dst;
    int            m_major;
    logic          m_irq = 1'b0;

    always #5 clk = ~clk;

    ring_dma_chan u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_src_base (cfg_src_base),
        .cfg_dst_addr (cfg_dst_addr),
        .cfg_src_off  (cfg_src_off),
        .cfg_dst_off  (cfg_dst_off),
        .cfg_src_mod  (cfg_src_mod),
        .cfg_nbytes   (cfg_nbytes),
        .cfg_major    (cfg_major),
        .req          (req),
        .irq_clr      (irq_clr),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .per_wr_en    (per_wr_en),
        .per_wr_addr  (per_wr_addr),
        .per_wr_data  (per_wr_data),
        .irq          (irq)
    );

    // Memory content is a bijection of the address, so data reveals the source
    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_A5A5;
    endfunction

    // Memory model: one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);
    end

    function automatic logic [AW-1:0] src_next(input logic [AW-1:0] a,
                                               input logic [15:0] off,
                                               input logic [4:0] smod);
        logic [AW-1:0] s;
        logic [AW-1:0] low;
        s = a + {{16{off[15]}}, off};
        if (smod == 0) return s;
        low = (32'h1 << smod) - 1;
        return (a & ~low) | (s & low);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per peripheral write
    always @(negedge clk) begin
        if (rst_n && per_wr_en) begin
            exp_t e;
            writes++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 R8 R9 unexpected write act=%0h exp=none", per_wr_addr);
            end else begin
                e = exp_q.pop_front();
                if (per_wr_addr !== e.a || per_wr_data !== e.d) begin
                    n_bad++;
                    $display("FAIL R2 R3 R4 R5 write act=%0h/%0h exp=%0h/%0h",
                             per_wr_addr, per_wr_data, e.a, e.d);
                end
            end
        end
    end

    task automatic model_reload();
        m_src   = cfg_src_base;
        m_dst   = cfg_dst_addr;
        m_major = (cfg_major == 0) ? 1 : int'(cfg_major);
    endtask

    // Driver side of the scoreboard: push one minor loop of expectations
    task automatic push_loop();
        int beats;
        beats = int'(cfg_nbytes) / 4;
        if (beats == 0) beats = 1;
        for (int b = 0; b < beats; b++) begin
            exp_q.push_back({m_dst, memf(m_src)});
            m_src = src_next(m_src, cfg_src_off, cfg_src_mod);
            m_dst = m_dst + {{16{cfg_dst_off[15]}}, cfg_dst_off};
            exp_writes++;
        end
        m_major--;
        if (m_major == 0) begin
            m_irq   = 1'b1;
            m_major = (cfg_major == 0) ? 1 : int'(cfg_major);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    // Wait for the last expected write, then n more falling edges
    task automatic drain(input int n);
        while (exp_q.size() != 0) begin
            @(negedge clk);
            #1;
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic run_loop(input string tag);
        push_loop();
        pulse_req();
        drain(3);
        check(irq === m_irq, tag, {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        m_irq = 1'b0;
        check(irq === 1'b0, "R7 irq cleared", {31'd0, irq}, 0);
    endtask

    task automatic reconfig(input logic [AW-1:0] sb, input logic [AW-1:0] da,
                            input logic [15:0] so, input logic [15:0] dof,
                            input logic [4:0] sm, input logic [11:0] nb,
                            input logic [15:0] mj);
        @(negedge clk);
        cfg_en       = 1'b0;
        cfg_src_base = sb;
        cfg_dst_addr = da;
        cfg_src_off  = so;
        cfg_dst_off  = dof;
        cfg_src_mod  = sm;
        cfg_nbytes   = nb;
        cfg_major    = mj;
        repeat (2) @(negedge clk);
        model_reload();
        cfg_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_rd_en === 1'b0, "R1 rd idle after reset", {31'd0, mem_rd_en}, 0);
        check(per_wr_en === 1'b0, "R1 wr idle after reset", {31'd0, per_wr_en}, 0);
        check(irq === 1'b0, "R1 irq low after reset", {31'd0, irq}, 0);

        // Window of 64 bytes starting near its top: wraps on the first loop
        reconfig(32'h8000_1038, 32'h4000_0020, 16'd4, 16'd0, 5'd6, 12'd16, 16'd3);
        run_loop("R6 irq after loop 1");
        run_loop("R6 irq after loop 2");
        run_loop("R6 irq after loop 3");
        run_loop("R7 irq sticky after loop 4");
        clear_irq();

        // Requests during a loop are held and merge into one
        push_loop();
        push_loop();
        pulse_req();
        pulse_req();
        pulse_req();
        drain(10);
        check(writes == exp_writes, "R8 merged request count", writes, exp_writes);
        check(irq === m_irq, "R6 irq after loop 6", {31'd0, irq}, {31'd0, m_irq});
        clear_irq();

        // Completion coinciding with a held clear: set wins
        run_loop("R6 irq after loop 7");
        run_loop("R6 irq after loop 8");
        push_loop();
        @(negedge clk) irq_clr = 1'b1;
        pulse_req();
        drain(2);
        check(irq === 1'b1, "R7 set beats clear", {31'd0, irq}, 1);
        irq_clr = 1'b0;
        clear_irq();

        // Disabled: requests dropped
        @(negedge clk) cfg_en = 1'b0;
        begin
            int w0;
            w0 = writes;
            pulse_req();
            repeat (12) @(negedge clk);
            check(writes == w0, "R9 request dropped while disabled", writes, w0);
        end

        // No window, incrementing destination, carry into upper bits
        reconfig(32'h0000_0FF8, 32'h4000_0100, 16'd4, 16'd4, 5'd0, 12'd12, 16'd2);
        run_loop("R3 R4 linear loop B1 irq");
        run_loop("R6 loop B2 irq");
        clear_irq();

        // Negative source step inside a 16-byte window
        reconfig(32'h2000_0008, 32'h4000_0000, 16'hFFFC, 16'd0, 5'd4, 12'd16, 16'd4);
        run_loop("R3 R5 downward loop C1 irq");
        run_loop("R5 downward loop C2 irq");

        // Disable during a loop: the loop completes, then state reloads
        push_loop();
        pulse_req();
        cfg_en = 1'b0;
        drain(4);
        check(writes == exp_writes, "R9 loop finished after disable", writes, exp_writes);
        model_reload();
        cfg_en = 1'b1;
        run_loop("R9 major counter reloaded on enable");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
        check(writes == exp_writes, "R2 total write count", writes, exp_writes);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule